// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This controller collects interrupt requests from six sources for a small processor core. Each source pulses its request line for a cycle. The pulse is caught in a per-source pending bit, and that bit stays set until the accept handshake or software clears it. Software can never set it. A mask register lets software block sources one by one. Source 0 is never masked, and the sources above the range of the mask register share its top bit. A global enable bit gates every source, source 0 included.

When a source is pending, unmasked and the global enable is set, the controller raises a request to the core. It also presents the number and vector address of the winning source. Source 0 wins first, and after that a lower index wins over a higher one. The core answers with a one-cycle accept pulse. That pulse clears the global enable and the winning pending bit, and sets a stack-frame flag. A return strobe sets the global enable again and drops the flag. An enable command sets the global enable, and in the same cycle it can clear a chosen set of pending bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset (rst_n low), all pending bits, the mask register, the global enable and the stack-frame flag are 0, and irq_req is 0.
- R2: A 1 on req_in[i] at a clock edge sets pending bit i, and the bit holds until it is cleared.
- R3: When clr_we is 1, every pending bit whose clr_pat bit is 1 is cleared. A request on the same bit in the same cycle wins, and the bit stays set. A clear never sets a bit.
- R4: mask_we loads mask_d into the mask register. Mask bit k (1 = allowed) gates source k+1. Sources with an index above MASK_W all use mask bit MASK_W-1. Source 0 ignores the mask.
- R5: irq_req is 1 exactly when the global enable is 1 and at least one pending bit is allowed by the mask. With the enable at 0, no source raises irq_req, source 0 included.
- R6: When several allowed sources are pending, the one with the lowest index is selected, and its index appears on src_out.
- R7: vec_out equals VEC_BASE + 2 × src_out while irq_req is 1.
- R8: irq_ack while irq_req is 1 is an accept. In the next cycle the global enable is 0, the accepted pending bit is clear unless its source requested again in the accept cycle, and sf_out is 1.
- R9: rti sets the global enable and clears sf_out at the next edge. An accept in the same cycle takes precedence for both.
- R10: ei_set sets the global enable at the next edge. Together with clr_we it acts as one enable command that also clears the clr_pat bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | NSRC | Per-source request pulses |
| clr_we | input | 1 | Software clear strobe for pending bits |
| clr_pat | input | NSRC | Pending bits to clear (1 = clear) |
| mask_we | input | 1 | Mask register write strobe |
| mask_d | input | MASK_W | New mask value (1 = allowed) |
| ei_set | input | 1 | Sets the global enable |
| irq_ack | input | 1 | One-cycle accept pulse from the core |
| rti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vec_out | output | VEC_W | Vector address of the selected source |
| src_out | output | clog2(NSRC) | Index of the selected source |
| sf_out | output | 1 | Stack-frame flag |

## Verification
The bench uses the default parameters: six sources, a four-bit mask and a vector base of 0x10. With these values, sources 4 and 5 share the top mask bit, so the shared-bit rule gets exercised along with the unmaskable source 0. Directed sequences cover several cases: a request arriving together with a clear, an accept arriving together with a return, and a masked source that becomes pending once the mask opens. After those, a long random phase compares every cycle against a behavioural model, and it produces overlapping requests whose winner must follow the priority order.

// File: rtl/prio_irq_pkg.sv
// Shared helpers for the priority interrupt controller.
// Assumes source 0 is the unmaskable source.
package prio_irq_pkg;

    // Mask bit that governs source idx (idx >= 1); sources past the mask share its top bit.
    function automatic int mask_bit_of(input int idx, input int mask_w);
        if (idx - 1 < mask_w)
            return idx - 1;
        return mask_w - 1;
    endfunction

endpackage

// File: rtl/irq_latch_bank.sv
// Pending-request bits, one per source.
// A request sets a bit; a clear vector resets it. A request beats a clear in the same cycle.
// Assumes the clear vector already merges the software clears and the accept clear.
module irq_latch_bank #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_in,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] lat_q
);

    // Update the pending bits: set by request, else cleared by the clear vector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else
            lat_q <= (lat_q & ~clr_vec) | req_in;
    end

endmodule

// File: rtl/irq_mask_gate.sv
// Mask register and per-source eligibility.
// Source 0 bypasses the mask. Source i >= 1 uses the mask bit given by the package helper.
module irq_mask_gate #(
    parameter int NSRC   = 6,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_d,
    input  logic [NSRC-1:0]   lat_q,
    output logic [NSRC-1:0]   elig
);
    import prio_irq_pkg::*;

    logic [MASK_W-1:0] mask_q;

    // Hold the mask register; software loads it with a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_d;
    end

    assign elig[0] = lat_q[0];

    for (genvar i = 1; i < NSRC; i++) begin : g_gate
        localparam int MB = mask_bit_of(i, MASK_W);
        assign elig[i] = lat_q[i] & mask_q[MB];
    end

endmodule

// File: rtl/irq_prio_sel.sv
// Fixed-priority selector: the lowest eligible index wins.
// Gives the index, a one-hot of the winner and a pending flag gated by the global enable.
module irq_prio_sel #(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  elig,
    input  logic             ei_q,
    output logic             pend,
    output logic [IDX_W-1:0] sel_idx,
    output logic [NSRC-1:0]  sel_oh
);

    // Scan from high to low so that the lowest eligible index is written last.
    always_comb begin
        sel_idx = '0;
        sel_oh  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sel_idx = IDX_W'(i);
                sel_oh  = NSRC'(1) << i;
            end
        end
    end

    // A request reaches the core only while the global enable is set.
    assign pend = ei_q & (|elig);

endmodule

// File: rtl/irq_enable_ctl.sv
// Global enable flip-flop and stack-frame flag.
// An accept clears the enable and sets the flag, and wins over a return or an enable command.
module irq_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_fire,
    input  logic rti,
    input  logic ei_set,
    output logic ei_q,
    output logic sf_q
);

    // Global enable: cleared by an accept, set by a return or an enable command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ei_q <= 1'b0;
        else if (ack_fire)
            ei_q <= 1'b0;
        else if (rti || ei_set)
            ei_q <= 1'b1;
    end

    // Stack-frame flag: set by an accept, cleared by a return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sf_q <= 1'b0;
        else if (ack_fire)
            sf_q <= 1'b1;
        else if (rti)
            sf_q <= 1'b0;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Masked fixed-priority interrupt controller, top level.
// Assumes the core holds irq_ack for one cycle and saves and restores its own context.
module prio_irq_ctrl #(
    parameter int NSRC     = 6,
    parameter int MASK_W   = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_in,
    input  logic              clr_we,
    input  logic [NSRC-1:0]   clr_pat,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_d,
    input  logic              ei_set,
    input  logic              irq_ack,
    input  logic              rti,
    output logic              irq_req,
    output logic [VEC_W-1:0]  vec_out,
    output logic [IDX_W-1:0]  src_out,
    output logic              sf_out
);

    logic [NSRC-1:0] lat_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] sel_oh;
    logic [NSRC-1:0] clr_vec;
    logic            ei_q;
    logic            ack_fire;

    assign ack_fire = irq_ack & irq_req;
    assign clr_vec  = (clr_we ? clr_pat : '0) | (ack_fire ? sel_oh : '0);

    irq_latch_bank #(.NSRC(NSRC)) u_lat (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr_vec(clr_vec), .lat_q(lat_q)
    );

    irq_mask_gate #(.NSRC(NSRC), .MASK_W(MASK_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_d(mask_d),
        .lat_q(lat_q), .elig(elig)
    );

    irq_prio_sel #(.NSRC(NSRC), .IDX_W(IDX_W)) u_sel (
        .elig(elig), .ei_q(ei_q), .pend(irq_req), .sel_idx(src_out), .sel_oh(sel_oh)
    );

    irq_enable_ctl u_en (
        .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .rti(rti), .ei_set(ei_set),
        .ei_q(ei_q), .sf_q(sf_out)
    );

    // Vector address: base plus twice the source index.
    assign vec_out = VEC_W'(VEC_BASE) + (VEC_W'(src_out) << 1);

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Assertion checker for prio_irq_ctrl, attached by bind.
// Observes ports and the pending bits and the global enable inside the top.
module prio_irq_ctrl_chk #(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  req_in,
    input logic [NSRC-1:0]  lat_q,
    input logic             ei_q,
    input logic             irq_ack,
    input logic             irq_req,
    input logic             rti,
    input logic             sf_out,
    input logic [IDX_W-1:0] src_out
);

    // R2, R3: a pending bit rises only because of a request
    for (genvar i = 0; i < NSRC; i++) begin : g_rise
        p_rise_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lat_q[i]) |-> $past(req_in[i]));
    end

    // R5
    p_req_needs_ei_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ei_q);

    // R4: source 0 ignores the mask
    p_src0_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[0] && ei_q) |-> irq_req);

    // R6
    p_sel_is_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> |((lat_q >> src_out) & NSRC'(1)));

    // R8
    p_ack_clears_ei_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (!ei_q && sf_out));

    // R9
    p_rti_sets_ei_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !(irq_ack && irq_req)) |=> (ei_q && !sf_out));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .lat_q(lat_q), .ei_q(ei_q),
    .irq_ack(irq_ack), .irq_req(irq_req), .rti(rti), .sf_out(sf_out), .src_out(src_out)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    localparam int NSRC = 6, MASK_W = 4, VEC_W = 8, VEC_BASE = 16, IDX_W = 3;

    logic clk = 0, rst_n = 0;
    logic [NSRC-1:0] req_in = '0, clr_pat = '0;
    logic clr_we = 0, mask_we = 0, ei_set = 0, irq_ack = 0, rti = 0;
    logic [MASK_W-1:0] mask_d = '0;
    logic irq_req, sf_out;
    logic [VEC_W-1:0] vec_out;
    logic [IDX_W-1:0] src_out;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    prio_irq_ctrl #(.NSRC(NSRC), .MASK_W(MASK_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr_we(clr_we), .clr_pat(clr_pat),
        .mask_we(mask_we), .mask_d(mask_d), .ei_set(ei_set), .irq_ack(irq_ack), .rti(rti),
        .irq_req(irq_req), .vec_out(vec_out), .src_out(src_out), .sf_out(sf_out)
    );

    always #10 clk = ~clk;

    // Behavioural reference state
    bit m_lat[NSRC];
    bit m_mask[MASK_W];
    bit m_ei, m_sf;

    function automatic bit m_allowed(int i);
        if (i == 0) return 1;
        return m_mask[(i - 1 < MASK_W) ? i - 1 : MASK_W - 1];
    endfunction

    function automatic int m_winner();
        for (int i = 0; i < NSRC; i++)
            if (m_lat[i] && m_allowed(i)) return i;
        return -1;
    endfunction

    function automatic bit m_req();
        return m_ei && (m_winner() >= 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_lat[i]) m_lat[i] = 0;
            foreach (m_mask[i]) m_mask[i] = 0;
            m_ei = 0; m_sf = 0;
        end else begin
            bit acc;
            int w;
            acc = irq_ack && m_req();
            w = m_winner();
            foreach (m_lat[i]) begin
                if (req_in[i]) m_lat[i] = 1;
                else if ((clr_we && clr_pat[i]) || (acc && w == i)) m_lat[i] = 0;
            end
            if (mask_we) foreach (m_mask[i]) m_mask[i] = mask_d[i];
            if (acc) begin m_ei = 0; m_sf = 1; end
            else begin
                if (rti || ei_set) m_ei = 1;
                if (rti) m_sf = 0;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 irq_req (R2,R3,R4,R10)", irq_req, m_req());
            check("R8,R9 sf_out", sf_out, m_sf);
            if (m_req()) begin
                check("R6 src_out", src_out, m_winner());
                check("R7 vec_out", vec_out, VEC_BASE + 2 * m_winner());
            end
        end
    end

    task automatic idle();
        req_in = '0; clr_we = 0; clr_pat = '0; mask_we = 0; mask_d = '0;
        ei_set = 0; irq_ack = 0; rti = 0;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq_req after reset", irq_req, 0);
        check("R1 sf_out after reset", sf_out, 0);
        #1;
        // R4: mask closed, source 3 pends but does not request
        ei_set = 1; req_in = 6'b001000; step();
        @(negedge clk);
        check("R4 masked source 3", irq_req, 0);
        // R4: source 0 bypasses the mask
        #1 req_in = 6'b000001; step();
        @(negedge clk);
        check("R4 source 0 unmasked", irq_req, 1);
        check("R7 vector of source 0", vec_out, VEC_BASE);
        // R8: accept source 0
        #1 irq_ack = 1; step();
        @(negedge clk);
        check("R8 enable cleared", irq_req, 0);
        check("R8 sf set", sf_out, 1);
        // R9 with the mask now open: source 3 wins
        #1 rti = 1; mask_we = 1; mask_d = 4'b1111; step();
        @(negedge clk);
        check("R9 sf cleared", sf_out, 0);
        check("R6 source 3 wins", src_out, 3);
        // R3: clear with a simultaneous request keeps bit 3, and bit 5 is cleared
        #1 req_in = 6'b101000; step();
        #1 clr_we = 1; clr_pat = 6'b101000; req_in = 6'b001000; step();
        @(negedge clk);
        check("R3 request beats clear", src_out, 3);
        // R10: the enable command clears bit 3; R4: sources 4 and 5 share mask bit 3
        #1 irq_ack = 1; step();
        #1 ei_set = 1; clr_we = 1; clr_pat = 6'b001000; mask_we = 1; mask_d = 4'b0111;
        req_in = 6'b110000; step();
        @(negedge clk);
        check("R10 enable command", irq_req, 0);
        #1 mask_we = 1; mask_d = 4'b1000; step();
        @(negedge clk);
        check("R4 shared mask bit", src_out, 4);
        // R9: an accept together with a return, the accept wins
        #1 irq_ack = 1; rti = 1; step();
        @(negedge clk);
        check("R9 accept wins over return", sf_out, 1);
        #1 rti = 1; step();
        // Random phase, compared against the model every cycle
        for (int n = 0; n < 5000; n++) begin
            if ($urandom % 6 == 0) req_in = NSRC'($urandom);
            irq_ack = irq_req && ($urandom % 2 == 0);
            rti = sf_out && ($urandom % 5 == 0);
            if ($urandom % 20 == 0) begin mask_we = 1; mask_d = MASK_W'($urandom); end
            if ($urandom % 12 == 0) begin clr_we = 1; clr_pat = NSRC'($urandom); end
            ei_set = ($urandom % 30 == 0);
            step();
        end
        @(negedge clk);
        finish_run();
    end

endmodule